// File: doc/BRIEF.md
# Virtual-Processor Register Address Mapper

This block serves one cluster's register file of 32 physical entries, which a run-time configurable number of virtual processors (VPs) share. The entries fall into two classes. Shared registers are common to every VP. Private registers are replicated once per VP.

A configuration command gives the shared count and the private count. When the command is legal, the block stores it and derives how many VPs fit: the number of free entries after the shared ones, divided by the private count and rounded down. For example, 0 shared with 8 private gives 4 VPs, 4 shared with 4 private gives 7, and 7 shared with 1 private gives 25. After a reconfiguration the register contents held for each VP are undefined, so the caller reconfigures before a loop and not during one.

A lookup carries a VP index, a register class and a register number. It returns the physical entry one cycle later, or an error flag when the reference is out of range. Shared register `r` is entry `r`. Private register `r` of VP `v` is entry `shared + v*private + r`.

Top module: `vp_reg_mapper`

## Requirements
- R1: While reset is held and after it is released, the block holds 0 shared and 32 private registers, so `vp_count` is 1, and `cfg_err` and `rsp_valid` are 0.
- R2: A legal configuration sampled at a clock edge appears on `vp_count` right after that edge, as floor((32 - shared) / private).
- R3: A configuration with private = 0 or shared + private > 32 is rejected. `cfg_err` is 1 for the cycle after the edge, and the stored counts and `vp_count` stay unchanged.
- R4: A lookup with `lk_class` = 1 (shared) and an in-range reference returns address equal to the register number.
- R5: A lookup with `lk_class` = 0 (private) and an in-range reference returns address shared + vp*private + register.
- R6: A lookup whose VP index is at or above `vp_count` returns `rsp_err` = 1 and address 0, in either class.
- R7: A lookup whose register number is at or above the size of its class returns `rsp_err` = 1 and address 0.
- R8: `rsp_valid` equals `lk_valid` from the previous edge. When `rsp_valid` is 0, both `rsp_addr` and `rsp_err` are 0.
- R9: A lookup sampled at the same edge as a configuration is resolved with the configuration that was in force before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, released synchronously |
| cfg_valid | input | 1 | Configuration command strobe |
| cfg_shared | input | 6 | Requested shared register count |
| cfg_private | input | 6 | Requested private register count per VP |
| cfg_err | output | 1 | Previous command was rejected |
| vp_count | output | 8 | Number of resident VPs |
| lk_valid | input | 1 | Lookup request strobe |
| lk_vp | input | 7 | VP index |
| lk_class | input | 1 | Register class: 1 shared, 0 private |
| lk_reg | input | 6 | Register number within the class |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_addr | output | 5 | Physical register entry |
| rsp_err | output | 1 | Lookup was out of range |

## Verification
The embedded properties assume that the request strobes and fields are driven to known values from time zero. They also assume that no command arrives during the two cycles in which the internal reset is still being released. The bench drives every input to zero before reset and holds it idle through release. It changes inputs only on falling edges. Its random phase mixes legal and illegal counts with VP indices and register numbers that straddle the current limits, so both the accept and the error paths stay under test.

// File: rtl/vpmap_pkg.sv
package vpmap_pkg;
  typedef enum logic {
    RC_PRIVATE = 1'b0,
    RC_SHARED  = 1'b1
  } reg_class_e;
endpackage

// File: rtl/vpmap_rst_sync.sv
module vpmap_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_in_n,
  output logic rst_out_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_out_n = sync_q[STAGES-1];
endmodule

// File: rtl/vpmap_cfg.sv
module vpmap_cfg #(
  parameter int unsigned NREGS = 32,
  parameter int unsigned MAXVP = 128,
  localparam int unsigned CW = $clog2(NREGS + 1),
  localparam int unsigned VW = $clog2(MAXVP + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_valid,
  input  logic [CW-1:0] cfg_shared,
  input  logic [CW-1:0] cfg_private,
  output logic [CW-1:0] shared_q,
  output logic [CW-1:0] private_q,
  output logic [VW-1:0] vp_count_q,
  output logic          cfg_err_q
);
  localparam int unsigned PW = 2 * CW;
  localparam int unsigned SW = CW + 1;

  logic [SW-1:0]    sum_w;
  logic             legal_w;
  logic [CW-1:0]    free_w;
  logic [NREGS-1:0] fits_w;
  logic [VW-1:0]    raw_cnt_w;
  logic [VW-1:0]    cnt_w;

  logic          upd_en;
  logic [CW-1:0] shared_d;
  logic [CW-1:0] private_d;
  logic [VW-1:0] count_d;
  logic          cerr_d;

  assign sum_w   = {1'b0, cfg_shared} + {1'b0, cfg_private};
  assign legal_w = (cfg_private != '0) && (sum_w <= SW'(NREGS));
  assign free_w  = CW'(NREGS) - cfg_shared;

  // One comparator per candidate VP count: k VPs fit when k*private <= free.
  for (genvar k = 1; k <= NREGS; k++) begin : g_fit
    assign fits_w[k-1] = (PW'(k) * PW'(cfg_private)) <= PW'(free_w);
  end

  assign raw_cnt_w = VW'($countones(fits_w));
  assign cnt_w     = (raw_cnt_w > VW'(MAXVP)) ? VW'(MAXVP) : raw_cnt_w;

  always_comb begin
    upd_en    = 1'b0;
    cerr_d    = 1'b0;
    shared_d  = shared_q;
    private_d = private_q;
    count_d   = vp_count_q;
    if (cfg_valid) begin
      if (legal_w) begin
        upd_en    = 1'b1;
        shared_d  = cfg_shared;
        private_d = cfg_private;
        count_d   = cnt_w;
      end else begin
        cerr_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shared_q   <= '0;
      private_q  <= CW'(NREGS);
      vp_count_q <= VW'(1);
      cfg_err_q  <= 1'b0;
    end else begin
      if (upd_en) begin
        shared_q   <= shared_d;
        private_q  <= private_d;
        vp_count_q <= count_d;
      end
      cfg_err_q <= cerr_d;
    end
  end

  // R3
  keep_on_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err_q |-> (shared_q == $past(shared_q) && private_q == $past(private_q)
                   && vp_count_q == $past(vp_count_q)));

  // R2
  stored_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (private_q != '0) && (({1'b0, shared_q} + {1'b0, private_q}) <= SW'(NREGS)));

  // R2
  count_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vp_count_q != '0) && (vp_count_q <= VW'(NREGS)));
endmodule

// File: rtl/vpmap_lookup.sv
module vpmap_lookup
  import vpmap_pkg::*;
#(
  parameter int unsigned NREGS = 32,
  parameter int unsigned MAXVP = 128,
  localparam int unsigned CW = $clog2(NREGS + 1),
  localparam int unsigned VW = $clog2(MAXVP + 1),
  localparam int unsigned IW = $clog2(MAXVP),
  localparam int unsigned AW = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] shared_q,
  input  logic [CW-1:0] private_q,
  input  logic [VW-1:0] vp_count_q,
  input  logic          lk_valid,
  input  logic [IW-1:0] lk_vp,
  input  logic          lk_class,
  input  logic [CW-1:0] lk_reg,
  output logic          rsp_valid,
  output logic [AW-1:0] rsp_addr,
  output logic          rsp_err
);
  localparam int unsigned MW = IW + CW + 2;

  reg_class_e    cls_w;
  logic          vp_ok_w;
  logic [CW-1:0] limit_w;
  logic          reg_ok_w;
  logic [MW-1:0] base_w;
  logic [MW-1:0] full_w;

  logic          valid_d;
  logic [AW-1:0] addr_d;
  logic          err_d;

  assign cls_w    = reg_class_e'(lk_class);
  assign vp_ok_w  = VW'(lk_vp) < vp_count_q;
  assign limit_w  = (cls_w == RC_SHARED) ? shared_q : private_q;
  assign reg_ok_w = lk_reg < limit_w;
  assign base_w   = (cls_w == RC_SHARED) ? '0
                  : (MW'(shared_q) + MW'(lk_vp) * MW'(private_q));
  assign full_w   = base_w + MW'(lk_reg);

  always_comb begin
    valid_d = lk_valid;
    err_d   = 1'b0;
    addr_d  = '0;
    if (lk_valid) begin
      if (vp_ok_w && reg_ok_w) addr_d = AW'(full_w);
      else                     err_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_addr  <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= valid_d;
      rsp_addr  <= addr_d;
      rsp_err   <= err_d;
    end
  end

  // R6
  vp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lk_valid) && (VW'($past(lk_vp)) >= $past(vp_count_q))) |-> rsp_err);

  // R8
  err_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_valid && rsp_addr == '0));

  // R8
  idle_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(lk_valid) |-> (!rsp_valid && rsp_addr == '0));

  // R4
  shared_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lk_valid) && $past(lk_class) && !rsp_err) |-> (CW'(rsp_addr) < $past(shared_q)));
endmodule

// File: rtl/vp_reg_mapper.sv
module vp_reg_mapper #(
  parameter int unsigned NREGS = 32,
  parameter int unsigned MAXVP = 128,
  localparam int unsigned CW = $clog2(NREGS + 1),
  localparam int unsigned VW = $clog2(MAXVP + 1),
  localparam int unsigned IW = $clog2(MAXVP),
  localparam int unsigned AW = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_valid,
  input  logic [CW-1:0] cfg_shared,
  input  logic [CW-1:0] cfg_private,
  output logic          cfg_err,
  output logic [VW-1:0] vp_count,
  input  logic          lk_valid,
  input  logic [IW-1:0] lk_vp,
  input  logic          lk_class,
  input  logic [CW-1:0] lk_reg,
  output logic          rsp_valid,
  output logic [AW-1:0] rsp_addr,
  output logic          rsp_err
);
  logic          rst_int_n;
  logic [CW-1:0] shared_q;
  logic [CW-1:0] private_q;

  vpmap_rst_sync #(.STAGES(2)) u_rst (
    .clk      (clk),
    .rst_in_n (rst_n),
    .rst_out_n(rst_int_n)
  );

  vpmap_cfg #(.NREGS(NREGS), .MAXVP(MAXVP)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .cfg_valid  (cfg_valid),
    .cfg_shared (cfg_shared),
    .cfg_private(cfg_private),
    .shared_q   (shared_q),
    .private_q  (private_q),
    .vp_count_q (vp_count),
    .cfg_err_q  (cfg_err)
  );

  vpmap_lookup #(.NREGS(NREGS), .MAXVP(MAXVP)) u_lk (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .shared_q  (shared_q),
    .private_q (private_q),
    .vp_count_q(vp_count),
    .lk_valid  (lk_valid),
    .lk_vp     (lk_vp),
    .lk_class  (lk_class),
    .lk_reg    (lk_reg),
    .rsp_valid (rsp_valid),
    .rsp_addr  (rsp_addr),
    .rsp_err   (rsp_err)
  );
endmodule

// File: tb/sim_vp_reg_mapper.sv
`timescale 1ns/1ps
module sim_vp_reg_mapper;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_valid = 1'b0;
  logic [5:0] cfg_shared = '0;
  logic [5:0] cfg_private = '0;
  logic       cfg_err;
  logic [7:0] vp_count;
  logic       lk_valid = 1'b0;
  logic [6:0] lk_vp = '0;
  logic       lk_class = 1'b0;
  logic [5:0] lk_reg = '0;
  logic       rsp_valid;
  logic [4:0] rsp_addr;
  logic       rsp_err;

  int checks = 0;
  int fails  = 0;
  bit cmp_en = 1'b0;
  bit done   = 1'b0;

  // reference model state
  int    m_sh = 0, m_pr = 32, m_cnt = 1;
  int    m_cerr = 0, m_rv = 0, m_ra = 0, m_re = 0;
  string m_tag = "R8";

  always #10 clk = ~clk;

  vp_reg_mapper u0 (.*);

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sh = 0; m_pr = 32; m_cnt = 1; m_cerr = 0; m_rv = 0; m_ra = 0; m_re = 0; m_tag = "R1";
    end else begin
      // lookup first, against the configuration in force before this edge
      m_rv = lk_valid; m_ra = 0; m_re = 0; m_tag = "R8";
      if (lk_valid) begin
        int lim;
        lim = lk_class ? m_sh : m_pr;
        if (int'(lk_vp) >= m_cnt) begin m_re = 1; m_tag = "R6"; end
        else if (int'(lk_reg) >= lim) begin m_re = 1; m_tag = "R7"; end
        else if (lk_class) begin m_ra = int'(lk_reg); m_tag = "R4"; end
        else begin m_ra = m_sh + int'(lk_vp) * m_pr + int'(lk_reg); m_tag = "R5"; end
        if (cfg_valid) m_tag = {m_tag, " R9"};
      end
      m_cerr = 0;
      if (cfg_valid) begin
        if (cfg_private == 0 || int'(cfg_shared) + int'(cfg_private) > 32) m_cerr = 1;
        else begin
          m_sh = cfg_shared; m_pr = cfg_private; m_cnt = (32 - m_sh) / m_pr;
        end
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en) begin
      check("R2 vp_count", int'(vp_count), m_cnt);
      check("R3 cfg_err", int'(cfg_err), m_cerr);
      check("R8 rsp_valid", int'(rsp_valid), m_rv);
      check({m_tag, " rsp_addr"}, int'(rsp_addr), m_ra);
      check({m_tag, " rsp_err"}, int'(rsp_err), m_re);
    end
  end

  task automatic do_cfg(input int sh, input int pr);
    cfg_valid = 1'b1; cfg_shared = 6'(sh); cfg_private = 6'(pr);
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  task automatic do_lk(input int vp, input int cls, input int rg);
    lk_valid = 1'b1; lk_vp = 7'(vp); lk_class = cls[0]; lk_reg = 6'(rg);
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 while reset held
    check("R1 count in reset", int'(vp_count), 1);
    check("R1 rsp_valid in reset", int'(rsp_valid), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 after release
    check("R1 count after reset", int'(vp_count), 1);
    check("R1 cfg_err after reset", int'(cfg_err), 0);
    cmp_en = 1'b1;

    do_cfg(0, 8);                       // R2: 4 VPs
    check("R2 0/8 count", int'(vp_count), 4);
    do_lk(3, 0, 7); @(negedge clk);     // R5: 31
    do_lk(4, 0, 0);                     // R6
    do_lk(0, 0, 8);                     // R7
    do_lk(0, 1, 0);                     // R7: no shared regs

    do_cfg(4, 4);
    check("R2 4/4 count", int'(vp_count), 7);
    do_lk(6, 0, 3);                     // R5: 31
    do_lk(2, 1, 3);                     // R4: 3
    do_lk(0, 1, 4);                     // R7
    do_lk(7, 1, 0);                     // R6 shared class

    do_cfg(7, 1);
    check("R2 7/1 count", int'(vp_count), 25);
    do_lk(24, 0, 0);                    // R5: 31
    do_lk(25, 0, 0);                    // R6

    do_cfg(5, 0);                       // R3 reject
    check("R3 zero private keeps count", int'(vp_count), 25);
    do_cfg(30, 3);                      // R3 reject
    check("R3 overfull keeps count", int'(vp_count), 25);
    do_lk(24, 1, 6);                    // R4 under kept config

    do_cfg(0, 1);
    check("R2 0/1 count", int'(vp_count), 32);
    // R9: lookup together with reconfiguration resolves under old config
    cfg_valid = 1'b1; cfg_shared = 6'd0; cfg_private = 6'd16;
    lk_valid = 1'b1; lk_vp = 7'd5; lk_class = 1'b0; lk_reg = 6'd0;
    @(negedge clk);
    cfg_valid = 1'b0; lk_valid = 1'b0;
    check("R9 addr old config", int'(rsp_addr), 5);
    check("R9 err old config", int'(rsp_err), 0);
    do_lk(1, 0, 15);                    // R5: 31 under new config
    do_lk(2, 0, 0);                     // R6

    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 9);
      cfg_valid   = (r == 0);
      cfg_shared  = 6'($urandom_range(0, 34));
      cfg_private = 6'($urandom_range(0, 12));
      lk_valid    = (r > 3);
      lk_class    = 1'($urandom_range(0, 1));
      lk_vp       = 7'($urandom_range(0, 35));
      lk_reg      = 6'($urandom_range(0, 33));
      @(negedge clk);
    end
    cfg_valid = 1'b0; lk_valid = 1'b0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule